// File: doc/BRIEF.md
# Two-Thread Priority Issue Selector

This block decides, every cycle, how many ready instructions each of two hardware threads may send to a shared pool of execution pipelines. Each thread reports, for five instruction classes, how many instructions are ready. The pool has a fixed mix of pipelines: three for branches and two each for simple ALU, integer, floating-point and memory work. Each thread's class queue also has its own issue cap.

One thread is primary and the other is secondary. The primary thread is served first. The secondary thread then fills whatever pipelines of each class the primary left idle in that same cycle. A registered priority select picks the primary thread. A per-thread stall input removes a thread from selection, so the other thread is offered every pipeline. Grants depend combinationally on the ready counts and the stall inputs. The priority choice is the only state in the block.

Ready and grant vectors are packed by class. Each class uses a 2-bit field: lane 0 is branch (bits 1:0), lane 1 is simple ALU (bits 3:2), lane 2 is integer (bits 5:4), lane 3 is FP (bits 7:6) and lane 4 is memory (bits 9:8).

Top module: `issel_top`

## Requirements
- R1: When the primary thread is not stalled, its grant in each class lane equals min(ready count, queue cap, pipelines of that class). Lane 0 is branch, lanes 1 to 4 are ALU, integer, FP and memory, and each lane is a 2-bit field.
- R2: A thread's grant in any class never exceeds that thread's ready count for the class.
- R3: The two threads' grants for one class never add up to more than that class's pipelines: 3 for branch and 2 for each other class.
- R4: The secondary thread's grant in each class equals min(its ready count, queue cap, pipelines minus the primary's grant in that class).
- R5: A stalled thread gets zero grants in every class. While it is stalled, the other thread is served as if it were the only thread. When both threads are stalled, every grant is zero.
- R6: prioSel (0 = thread 0 primary, 1 = thread 1 primary) is sampled on the rising clock edge and governs the grants from the following cycle on. During reset and after it, thread 0 is primary until a 1 is sampled.
- R7: One thread's grants across all classes add up to at most 11 in a cycle.
- R8: The queue cap is 3 for branch and 2 for every other class, so a ready count of 3 in a non-branch class yields a grant of at most 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| prioSel | input | 1 | Requested primary thread, takes effect next cycle |
| stallT0 | input | 1 | Thread 0 stalled, excluded from grants |
| stallT1 | input | 1 | Thread 1 stalled, excluded from grants |
| rdyT0 | input | 10 | Thread 0 per-class ready counts, 5 lanes of 2 bits |
| rdyT1 | input | 10 | Thread 1 per-class ready counts, 5 lanes of 2 bits |
| grantT0 | output | 10 | Thread 0 per-class grant counts |
| grantT1 | output | 10 | Thread 1 per-class grant counts |

## Verification
Grants follow ready and stall changes within the same cycle. The bench therefore drives these inputs on the falling edge and samples the grants a quarter period later, before the next rising edge. A change of prioSel takes effect only after one rising edge. The bench checks this twice: once before that edge, where the old priority must still hold, and once after it, where the new one must apply. Expected grants come from an independent min-of-three model with the primary thread served first.

// File: rtl/issel_pkg.sv
package issel_pkg;

  typedef struct packed {
    logic primIsT1;  // thread 1 holds priority this cycle
    logic t0Kill;    // thread 0 excluded from selection
    logic t1Kill;    // thread 1 excluded from selection
  } issel_strobe_t;

  function automatic int minOf3(input int a, input int b, input int c);
    int m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

  function automatic int pipesFor(input int cls, input int brPipes, input int othPipes);
    return (cls == 0) ? brPipes : othPipes;
  endfunction

endpackage

// File: rtl/issel_ctrl.sv
module issel_ctrl
  import issel_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          prioSel,
  input  logic          stallT0,
  input  logic          stallT1,
  output issel_strobe_t ctl
);

  logic prioReg;

  // priority choice is registered: applies from the cycle after sampling
  always_ff @(posedge clk) begin
    if (!rstN) prioReg <= 1'b0;
    else       prioReg <= prioSel;
  end

  always_comb begin
    ctl.primIsT1 = prioReg;
    ctl.t0Kill   = stallT0;
    ctl.t1Kill   = stallT1;
  end

endmodule

// File: rtl/issel_datapath.sv
module issel_datapath
  import issel_pkg::*;
#(
  parameter int NCLS      = 5,
  parameter int CNT_W     = 2,
  parameter int BR_PIPES  = 3,
  parameter int OTH_PIPES = 2,
  parameter int BR_CAP    = 3,
  parameter int OTH_CAP   = 2
) (
  input  issel_strobe_t          ctl,
  input  logic [NCLS*CNT_W-1:0]  rdyT0,
  input  logic [NCLS*CNT_W-1:0]  rdyT1,
  output logic [NCLS*CNT_W-1:0]  grantT0,
  output logic [NCLS*CNT_W-1:0]  grantT1
);

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    localparam int PIPES = pipesFor(c, BR_PIPES, OTH_PIPES);
    localparam int CAP   = (c == 0) ? BR_CAP : OTH_CAP;

    logic [CNT_W-1:0] r0, r1, primRdy, secRdy, primGnt, secGnt;

    always_comb begin
      r0      = ctl.t0Kill ? '0 : rdyT0[c*CNT_W +: CNT_W];
      r1      = ctl.t1Kill ? '0 : rdyT1[c*CNT_W +: CNT_W];
      primRdy = ctl.primIsT1 ? r1 : r0;
      secRdy  = ctl.primIsT1 ? r0 : r1;
      primGnt = CNT_W'(minOf3(int'(primRdy), CAP, PIPES));
      // secondary only backfills what the primary left idle
      secGnt  = CNT_W'(minOf3(int'(secRdy), CAP, PIPES - int'(primGnt)));
    end

    assign grantT0[c*CNT_W +: CNT_W] = ctl.primIsT1 ? secGnt  : primGnt;
    assign grantT1[c*CNT_W +: CNT_W] = ctl.primIsT1 ? primGnt : secGnt;
  end

endmodule

// File: rtl/issel_top.sv
module issel_top
  import issel_pkg::*;
#(
  parameter int NCLS       = 5,
  parameter int CNT_W      = 2,
  parameter int BR_PIPES   = 3,
  parameter int OTH_PIPES  = 2,
  parameter int BR_CAP     = 3,
  parameter int OTH_CAP    = 2,
  parameter int THREAD_MAX = 11
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  prioSel,
  input  logic                  stallT0,
  input  logic                  stallT1,
  input  logic [NCLS*CNT_W-1:0] rdyT0,
  input  logic [NCLS*CNT_W-1:0] rdyT1,
  output logic [NCLS*CNT_W-1:0] grantT0,
  output logic [NCLS*CNT_W-1:0] grantT1
);

  issel_strobe_t ctl;

  issel_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .prioSel (prioSel),
    .stallT0 (stallT0),
    .stallT1 (stallT1),
    .ctl     (ctl)
  );

  issel_datapath #(
    .NCLS      (NCLS),
    .CNT_W     (CNT_W),
    .BR_PIPES  (BR_PIPES),
    .OTH_PIPES (OTH_PIPES),
    .BR_CAP    (BR_CAP),
    .OTH_CAP   (OTH_CAP)
  ) i_dp (
    .ctl     (ctl),
    .rdyT0   (rdyT0),
    .rdyT1   (rdyT1),
    .grantT0 (grantT0),
    .grantT1 (grantT1)
  );

endmodule

// File: rtl/issel_checker.sv
module issel_checker
  import issel_pkg::*;
#(
  parameter int NCLS       = 5,
  parameter int CNT_W      = 2,
  parameter int BR_PIPES   = 3,
  parameter int OTH_PIPES  = 2,
  parameter int BR_CAP     = 3,
  parameter int OTH_CAP    = 2,
  parameter int THREAD_MAX = 11
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  prioSel,
  input logic                  stallT0,
  input logic                  stallT1,
  input logic [NCLS*CNT_W-1:0] rdyT0,
  input logic [NCLS*CNT_W-1:0] rdyT1,
  input logic [NCLS*CNT_W-1:0] grantT0,
  input logic [NCLS*CNT_W-1:0] grantT1
);

  logic pastValid;
  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  int sum0, sum1;
  always_comb begin
    sum0 = 0;
    sum1 = 0;
    for (int c = 0; c < NCLS; c++) begin
      sum0 += int'(grantT0[c*CNT_W +: CNT_W]);
      sum1 += int'(grantT1[c*CNT_W +: CNT_W]);
    end
  end

  // R7: per-thread total limit
  a_r7_thread_total: assert property (@(posedge clk) disable iff (!rstN)
    (sum0 <= THREAD_MAX) && (sum1 <= THREAD_MAX));

  // R5: a stalled thread receives nothing
  a_r5_stall_t0: assert property (@(posedge clk) disable iff (!rstN)
    stallT0 |-> (grantT0 == '0));
  a_r5_stall_t1: assert property (@(posedge clk) disable iff (!rstN)
    stallT1 |-> (grantT1 == '0));

  for (genvar c = 0; c < NCLS; c++) begin : g_chk
    localparam int PIPES = pipesFor(c, BR_PIPES, OTH_PIPES);
    localparam int CAP   = (c == 0) ? BR_CAP : OTH_CAP;

    // R3: shared pipelines are never oversubscribed
    a_r3_class_limit: assert property (@(posedge clk) disable iff (!rstN)
      (int'(grantT0[c*CNT_W +: CNT_W]) + int'(grantT1[c*CNT_W +: CNT_W])) <= PIPES);

    // R2: no grant beyond what is ready
    a_r2_within_ready: assert property (@(posedge clk) disable iff (!rstN)
      (grantT0[c*CNT_W +: CNT_W] <= rdyT0[c*CNT_W +: CNT_W]) &&
      (grantT1[c*CNT_W +: CNT_W] <= rdyT1[c*CNT_W +: CNT_W]));

    // R6: priority sampled last edge governs this cycle (thread 0 case)
    a_r6_prio_t0: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && !$past(prioSel) && !stallT0) |->
      (int'(grantT0[c*CNT_W +: CNT_W]) ==
       minOf3(int'(rdyT0[c*CNT_W +: CNT_W]), CAP, PIPES)));

    // R6: priority sampled last edge governs this cycle (thread 1 case)
    a_r6_prio_t1: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && $past(prioSel) && !stallT1) |->
      (int'(grantT1[c*CNT_W +: CNT_W]) ==
       minOf3(int'(rdyT1[c*CNT_W +: CNT_W]), CAP, PIPES)));
  end

endmodule

bind issel_top issel_checker #(
  .NCLS       (NCLS),
  .CNT_W      (CNT_W),
  .BR_PIPES   (BR_PIPES),
  .OTH_PIPES  (OTH_PIPES),
  .BR_CAP     (BR_CAP),
  .OTH_CAP    (OTH_CAP),
  .THREAD_MAX (THREAD_MAX)
) i_chk (.*);

// File: tb/test_issel_top.sv
`timescale 1ns/1ps
module test_issel_top;

  localparam int NCLS = 5;
  localparam int CW   = 2;
  localparam int VW   = NCLS*CW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          prioSel = 1'b0;
  logic          stallT0 = 1'b0;
  logic          stallT1 = 1'b0;
  logic [VW-1:0] rdyT0 = '0;
  logic [VW-1:0] rdyT1 = '0;
  logic [VW-1:0] grantT0, grantT1;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  issel_top i_issel_top (
    .clk(clk), .rstN(rstN), .prioSel(prioSel), .stallT0(stallT0), .stallT1(stallT1),
    .rdyT0(rdyT0), .rdyT1(rdyT1), .grantT0(grantT0), .grantT1(grantT1)
  );

  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // independent model: primary served first, secondary backfills
  function automatic void model(input logic p1, input logic s0, input logic s1,
                                input logic [VW-1:0] a, input logic [VW-1:0] b,
                                output logic [VW-1:0] e0, output logic [VW-1:0] e1);
    e0 = '0; e1 = '0;
    for (int c = 0; c < NCLS; c++) begin
      int pipes, cap, ra, rb, gp, gs;
      pipes = (c == 0) ? 3 : 2;
      cap   = (c == 0) ? 3 : 2;
      ra = s0 ? 0 : int'(a[c*CW +: CW]);
      rb = s1 ? 0 : int'(b[c*CW +: CW]);
      gp = mn(mn(p1 ? rb : ra, cap), pipes);
      gs = mn(mn(p1 ? ra : rb, cap), pipes - gp);
      e0[c*CW +: CW] = CW'(p1 ? gs : gp);
      e1[c*CW +: CW] = CW'(p1 ? gp : gs);
    end
  endfunction

  task automatic check(input string req, input logic p1);
    logic [VW-1:0] e0, e1;
    model(p1, stallT0, stallT1, rdyT0, rdyT1, e0, e1);
    nChecks++;
    if (grantT0 !== e0 || grantT1 !== e1) begin
      nFails++;
      $display("FAIL %s: grantT0=%h grantT1=%h expected %h %h", req, grantT0, grantT1, e0, e1);
    end
  endtask

  task automatic drive(input logic [VW-1:0] a, input logic [VW-1:0] b,
                       input logic s0, input logic s1);
    @(negedge clk);
    rdyT0 = a; rdyT1 = b; stallT0 = s0; stallT1 = s1;
    #5;
  endtask

  // lanes: {mem, fp, int, alu, br}
  function automatic logic [VW-1:0] pk(input int br, input int alu, input int it,
                                       input int fp, input int mem);
    return {CW'(mem), CW'(fp), CW'(it), CW'(alu), CW'(br)};
  endfunction

  task automatic t_reset();
    prioSel = 1'b1;  // ignored while in reset
    drive(pk(3,3,3,3,3), pk(3,3,3,3,3), 1'b0, 1'b0);
    check("R6 reset primary is thread0", 1'b0);
    @(negedge clk); prioSel = 1'b0;
    @(posedge clk); #1 rstN = 1'b1;
    #4;
    check("R1 full-ready primary caps", 1'b0);
  endtask

  task automatic t_backfill();
    drive(pk(1,2,0,1,2), pk(3,3,3,3,3), 1'b0, 1'b0);
    check("R4 secondary backfills leftovers", 1'b0);
    drive(pk(0,0,0,0,0), pk(3,3,3,3,3), 1'b0, 1'b0);
    check("R4 idle primary gives all pipes", 1'b0);
    drive(pk(2,1,2,0,1), pk(2,2,1,2,1), 1'b0, 1'b0);
    check("R3 shared class limits", 1'b0);
  endtask

  task automatic t_caps();
    drive(pk(3,3,1,3,0), pk(0,1,3,0,3), 1'b0, 1'b0);
    check("R8 queue caps", 1'b0);
    drive(pk(1,0,1,0,1), pk(1,1,0,1,0), 1'b0, 1'b0);
    check("R2 grant within ready", 1'b0);
  endtask

  task automatic t_total();
    drive(pk(3,3,3,3,3), pk(3,3,3,3,3), 1'b0, 1'b0);
    check("R7 total per thread", 1'b0);
    nChecks++;
    if (grantT0 !== pk(3,2,2,2,2) || grantT1 !== '0) begin
      nFails++;
      $display("FAIL R7: grantT0=%h grantT1=%h expected %h 0", grantT0, grantT1, pk(3,2,2,2,2));
    end
  endtask

  task automatic t_stall();
    drive(pk(3,3,3,3,3), pk(2,1,2,1,2), 1'b1, 1'b0);
    check("R5 primary stalled", 1'b0);
    drive(pk(1,2,1,2,1), pk(3,3,3,3,3), 1'b0, 1'b1);
    check("R5 secondary stalled", 1'b0);
    drive(pk(3,3,3,3,3), pk(3,3,3,3,3), 1'b1, 1'b1);
    check("R5 both stalled", 1'b0);
  endtask

  task automatic t_swap();
    drive(pk(2,2,2,2,2), pk(3,3,3,3,3), 1'b0, 1'b0);
    prioSel = 1'b1;
    #1;
    check("R6 old priority before edge", 1'b0);
    @(negedge clk); #5;
    check("R6 thread1 primary after edge", 1'b1);
    drive(pk(3,3,1,3,3), pk(1,0,2,2,1), 1'b0, 1'b0);
    check("R4 backfill thread0 secondary", 1'b1);
    drive(pk(3,3,3,3,3), pk(3,3,3,3,3), 1'b0, 1'b1);
    check("R5 thread1 primary stalled", 1'b1);
    @(negedge clk); prioSel = 1'b0; #5;
    check("R6 swap back held one cycle", 1'b1);
    @(negedge clk); #5;
    check("R6 swap back effective", 1'b0);
  endtask

  initial begin : watchdog
    #2000000;
    nChecks++; nFails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    t_reset();
    t_backfill();
    t_caps();
    t_total();
    t_stall();
    t_swap();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule